// File: doc/BRIEF.md
# Gauge Scan Sequencer Controller

This block is the timing and control core of a multi-gauge coil driver. It divides the bus clock by one of four ratios to produce a scan-step tick. A scan cycle is a fixed number of those ticks. In auto mode cycles follow one another with no gap. In manual mode software starts exactly one cycle at a time. Each gauge has a data register and a mode register. Software writes the master copy at any time. The slave copy, which drives the coil logic downstream, is reloaded from the master only at the moment a cycle starts.

Once per cycle, on the final tick, a synchronize flag is raised. It can also drive an interrupt. To clear it, software must first read the status register while the flag shows set, and then write a clear bit. The gauge enable register is only held and presented: it has no effect on scan timing or on the flag.

Top module: `gauge_scan_seq`

## Requirements
- R1: After reset the control, status and enable registers read 0, `irq` and `scanBusy` are 0, and every slave register is 0.
- R2: The control field at bits 3:2 of address 0 sets the tick divider. Codes 00, 01, 10 and 11 select 2^(B+1), 2^(B+2), 2^(B+3) and 2^B bus clocks, where B is `PRESCALE_LOG2` (default 9, which gives 1024, 2048, 4096 and 512). A cycle lasts `STEPS_PER_SCAN` ticks.
- R3: With auto mode off (bit 0 of address 0 = 0), writing 1 to bit 1 of address 0 while idle starts exactly one cycle. Bit 1 reads 1 while the cycle runs and 0 once it ends, and no further cycle follows.
- R4: A start write made while a cycle is running is ignored. The running cycle ends at its original time.
- R5: With auto mode on, cycles run back to back and `scanBusy` stays 1. Turning auto mode off lets the running cycle finish and then the sequencer stays idle.
- R6: Slave data and mode copies change only when a cycle starts, and then take the master values. Master writes made in mid-cycle are visible at the master address at once, but reach the slave copy only at the next start.
- R7: The sync flag (bit 0 of address 1) is set on the final tick of every cycle, even when the gauge enable register (address 2) is all zero.
- R8: `irq` is 1 exactly while the sync flag is set and the interrupt enable (bit 4 of address 0) is 1.
- R9: Writing 1 to bit 1 of address 1 clears the flag only if an earlier read of address 1 saw the flag set. Without such a read the write has no effect. Bit 1 of address 1 always reads 0.
- R10: If a qualified clear write falls on the same clock as the flag being set, the flag stays set. That clear write still uses up the qualification, so a later clear write needs a fresh read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| slaveData | output | NUM_GAUGES*DATA_W | Slave data copies, gauge 0 in the low bits |
| slaveMode | output | NUM_GAUGES*MODE_W | Slave mode copies, gauge 0 in the low bits |
| gaugeEn | output | NUM_GAUGES | Gauge enable register contents |
| scanBusy | output | 1 | A scan cycle is running |
| irq | output | 1 | Sync interrupt request |

Gauge g has its master data at address 8+2g and its master mode at address 9+2g.

## Verification
Two events can land on the same clock edge: the set of the sync flag on a cycle's final tick, and a qualified clear write. The bench counts bus clocks from a manual start. It arranges for the clear strobe to be sampled on exactly the edge where the cycle ends. It then checks that the flag survived. A second clear write must then have no effect, which shows that the qualification was consumed. The same edge-exact counting sets each divider's cycle length and the moment the slave copies may change.

// File: rtl/gss_pkg.sv
package gss_pkg;
  typedef struct packed {
    logic startReq;
    logic syncClr;
    logic statusRd;
  } busReq_t;

  typedef struct packed {
    logic loadSlaves;
  } seqStrobe_t;
endpackage

// File: rtl/gss_ctrl.sv
module gss_ctrl import gss_pkg::*; #(
  parameter int STEPS_PER_SCAN = 16,
  parameter int PRESCALE_LOG2  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  busReq_t    busReq,
  input  logic       cfgAuto,
  input  logic [1:0] cfgSel,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       syncFlag
);
  localparam int STEP_W = (STEPS_PER_SCAN > 1) ? $clog2(STEPS_PER_SCAN) : 1;
  localparam int PRE_W  = PRESCALE_LOG2 + 4;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS_PER_SCAN - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [STEP_W-1:0] step;
  logic [PRE_W-1:0]  ratioM1;
  logic              tickNow, lastTick, startNow, qualified;
  int                ratioLog2;

  always_comb begin
    ratioLog2 = (cfgSel == 2'b11) ? PRESCALE_LOG2 : PRESCALE_LOG2 + 1 + int'(cfgSel);
    ratioM1   = (PRE_W'(1) << ratioLog2) - PRE_W'(1);
  end

  assign tickNow  = busy && (preCnt >= ratioM1);
  assign lastTick = tickNow && (step == LAST_STEP);
  assign startNow = (!busy && (cfgAuto || busReq.startReq)) || (lastTick && cfgAuto);
  assign strobe.loadSlaves = startNow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step   <= '0;
      preCnt <= '0;
    end else if (startNow) begin
      busy   <= 1'b1;
      step   <= '0;
      preCnt <= '0;
    end else if (lastTick) begin
      busy   <= 1'b0;
      step   <= '0;
      preCnt <= '0;
    end else if (tickNow) begin
      step   <= step + STEP_W'(1);
      preCnt <= '0;
    end else if (busy) begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncFlag  <= 1'b0;
      qualified <= 1'b0;
    end else begin
      if (lastTick)
        syncFlag <= 1'b1;
      else if (busReq.syncClr && qualified)
        syncFlag <= 1'b0;
      if (busReq.syncClr)
        qualified <= 1'b0;
      else if (busReq.statusRd && syncFlag)
        qualified <= 1'b1;
    end
  end

  // R3: a cycle begins only on a start request or in auto mode
  a_r3_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(busReq.startReq || cfgAuto));

  // R4: a start write during a running cycle does not restart the prescaler
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busReq.startReq && !tickNow) |=> (preCnt != '0));

  // R7: the flag is raised only by a running cycle
  a_r7_set_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syncFlag) |-> $past(busy));

  // R9: a flag clear needs a prior qualifying read
  a_r9_qualified_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(syncFlag) |-> $past(busReq.syncClr && qualified));

  // R10: set beats a simultaneous clear, and the clear consumes qualification
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (lastTick && busReq.syncClr) |=> (syncFlag && !qualified));
endmodule

// File: rtl/gss_datapath.sv
module gss_datapath import gss_pkg::*; #(
  parameter int NUM_GAUGES = 4,
  parameter int DATA_W     = 8,
  parameter int MODE_W     = 4,
  parameter int ADDR_W     = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWdata,
  input  logic                         busWr,
  input  logic                         busRd,
  output logic [DATA_W-1:0]            busRdata,
  input  seqStrobe_t                   strobe,
  input  logic                         busy,
  input  logic                         syncFlag,
  output busReq_t                      busReq,
  output logic                         cfgAuto,
  output logic [1:0]                   cfgSel,
  output logic                         cfgIe,
  output logic [NUM_GAUGES*DATA_W-1:0] slaveData,
  output logic [NUM_GAUGES*MODE_W-1:0] slaveMode,
  output logic [NUM_GAUGES-1:0]        gaugeEn
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(2);
  localparam int GAUGE_BASE = 8;

  logic [NUM_GAUGES*DATA_W-1:0] masterData;
  logic [NUM_GAUGES*MODE_W-1:0] masterMode;
  logic wrCtrl, wrStat, wrEn;

  assign wrCtrl = busWr && (busAddr == A_CTRL);
  assign wrStat = busWr && (busAddr == A_STAT);
  assign wrEn   = busWr && (busAddr == A_EN);

  assign busReq.startReq = wrCtrl && busWdata[1];
  assign busReq.syncClr  = wrStat && busWdata[1];
  assign busReq.statusRd = busRd && (busAddr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgAuto <= 1'b0;
      cfgSel  <= 2'b00;
      cfgIe   <= 1'b0;
      gaugeEn <= '0;
    end else begin
      if (wrCtrl) begin
        cfgAuto <= busWdata[0];
        cfgSel  <= busWdata[3:2];
        cfgIe   <= busWdata[4];
      end
      if (wrEn)
        gaugeEn <= busWdata[NUM_GAUGES-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GAUGES; g++) begin : gGauge
    logic [DATA_W-1:0] mData, sData;
    logic [MODE_W-1:0] mMode, sMode;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mData <= '0;
        mMode <= '0;
        sData <= '0;
        sMode <= '0;
      end else begin
        if (busWr && busAddr == ADDR_W'(GAUGE_BASE + 2*g))
          mData <= busWdata;
        if (busWr && busAddr == ADDR_W'(GAUGE_BASE + 2*g + 1))
          mMode <= busWdata[MODE_W-1:0];
        if (strobe.loadSlaves) begin
          sData <= mData;
          sMode <= mMode;
        end
      end
    end
    assign masterData[g*DATA_W +: DATA_W] = mData;
    assign masterMode[g*MODE_W +: MODE_W] = mMode;
    assign slaveData[g*DATA_W +: DATA_W]  = sData;
    assign slaveMode[g*MODE_W +: MODE_W]  = sMode;
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == A_CTRL)
      busRdata = DATA_W'({cfgIe, cfgSel, busy, cfgAuto});
    else if (busAddr == A_STAT)
      busRdata = DATA_W'(syncFlag);
    else if (busAddr == A_EN)
      busRdata = DATA_W'(gaugeEn);
    for (int g = 0; g < NUM_GAUGES; g++) begin
      if (busAddr == ADDR_W'(GAUGE_BASE + 2*g))
        busRdata = masterData[g*DATA_W +: DATA_W];
      if (busAddr == ADDR_W'(GAUGE_BASE + 2*g + 1))
        busRdata = DATA_W'(masterMode[g*MODE_W +: MODE_W]);
    end
  end

  // R6: slave copies move only on a cycle-start load
  a_r6_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadSlaves |=> ($stable(slaveData) && $stable(slaveMode)));
endmodule

// File: rtl/gauge_scan_seq.sv
module gauge_scan_seq import gss_pkg::*; #(
  parameter int NUM_GAUGES     = 4,
  parameter int DATA_W         = 8,
  parameter int MODE_W         = 4,
  parameter int ADDR_W         = 5,
  parameter int STEPS_PER_SCAN = 16,
  parameter int PRESCALE_LOG2  = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWdata,
  output logic [DATA_W-1:0]            busRdata,
  input  logic                         busWr,
  input  logic                         busRd,
  output logic [NUM_GAUGES*DATA_W-1:0] slaveData,
  output logic [NUM_GAUGES*MODE_W-1:0] slaveMode,
  output logic [NUM_GAUGES-1:0]        gaugeEn,
  output logic                         scanBusy,
  output logic                         irq
);
  busReq_t    busReq;
  seqStrobe_t strobe;
  logic       cfgAuto, cfgIe, syncFlag;
  logic [1:0] cfgSel;

  gss_ctrl #(.STEPS_PER_SCAN(STEPS_PER_SCAN), .PRESCALE_LOG2(PRESCALE_LOG2)) uCtrl (
    .clk(clk), .rst_n(rst_n), .busReq(busReq), .cfgAuto(cfgAuto), .cfgSel(cfgSel),
    .strobe(strobe), .busy(scanBusy), .syncFlag(syncFlag)
  );

  gss_datapath #(.NUM_GAUGES(NUM_GAUGES), .DATA_W(DATA_W), .MODE_W(MODE_W),
                 .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr),
    .busRd(busRd), .busRdata(busRdata), .strobe(strobe), .busy(scanBusy),
    .syncFlag(syncFlag), .busReq(busReq), .cfgAuto(cfgAuto), .cfgSel(cfgSel),
    .cfgIe(cfgIe), .slaveData(slaveData), .slaveMode(slaveMode), .gaugeEn(gaugeEn)
  );

  assign irq = syncFlag && cfgIe;

  // R8: the interrupt never rises without the enable bit
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> cfgIe);
endmodule

// File: tb/tb_gauge_scan_seq.sv
module tb_gauge_scan_seq;
  localparam int NG = 4, DW = 8, MW = 4, AW = 5, STEPS = 4, PL = 2;

  logic clk = 1'b0, rst_n = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0, busRdata;
  logic [NG*DW-1:0] slaveData;
  logic [NG*MW-1:0] slaveMode;
  logic [NG-1:0] gaugeEn;
  logic scanBusy, irq;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  gauge_scan_seq #(.NUM_GAUGES(NG), .DATA_W(DW), .MODE_W(MW), .ADDR_W(AW),
                   .STEPS_PER_SCAN(STEPS), .PRESCALE_LOG2(PL)) dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busWr(busWr), .busRd(busRd), .slaveData(slaveData),
    .slaveMode(slaveMode), .gaugeEn(gaugeEn), .scanBusy(scanBusy), .irq(irq)
  );

  function automatic logic [DW-1:0] ctrlWord(logic au, logic st, logic [1:0] sel, logic ie);
    return {3'b000, ie, sel, st, au};
  endfunction

  function automatic int cycleLen(int sel);
    return STEPS * ((sel == 3) ? (1 << PL) : (1 << (PL + 1 + sel)));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (scanBusy) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic clearFlag();
    logic [DW-1:0] d;
    busRead(5'd1, d);
    busWrite(5'd1, 8'h02);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int n, badBusy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    busRead(5'd0, d); chk("R1 ctrl", d, 0);
    busRead(5'd1, d); chk("R1 status", d, 0);
    busRead(5'd2, d); chk("R1 enable", d, 0);
    chk("R1 irq/busy", {irq, scanBusy}, 0);
    chk("R1 slaves", {slaveData, slaveMode}, 0);

    // R2 divider sweep over all select codes, R3 manual single cycle
    for (int sel = 0; sel < 4; sel++) begin
      busWrite(5'd0, ctrlWord(1'b0, 1'b1, 2'(sel), 1'b0));
      waitIdle(n);
      chk($sformatf("R2 sel=%0d cycle length", sel), n, cycleLen(sel));
      clearFlag();
    end
    busRead(5'd0, d); chk("R3 start bit self-clears", d[1], 0);
    repeat (2 * cycleLen(0)) @(negedge clk);
    chk("R3 single cycle only", scanBusy, 0);

    // R4 start write mid-cycle ignored
    busWrite(5'd0, ctrlWord(1'b0, 1'b1, 2'd3, 1'b0));
    busRead(5'd0, d); chk("R3 start bit reads 1 while running", d[1], 1);
    n = 2;
    while (scanBusy) begin
      if (n == 5) begin
        busAddr = 5'd0; busWdata = ctrlWord(1'b0, 1'b1, 2'd3, 1'b0); busWr = 1'b1;
      end else busWr = 1'b0;
      @(negedge clk);
      n++;
    end
    busWr = 1'b0;
    chk("R4 cycle length unchanged", n, cycleLen(3));

    // R7 flag set with all gauges disabled; R8 irq gating
    busWrite(5'd2, 8'h00);
    chk("R8 irq low with enable off", irq, 0);
    busWrite(5'd0, ctrlWord(1'b0, 1'b0, 2'd3, 1'b1));
    chk("R8 irq follows flag and enable", irq, 1);
    busRead(5'd1, d); chk("R7 flag set, R9 clear bit reads 0", d, 8'h01);
    busWrite(5'd1, 8'h02);
    chk("R9 qualified clear", irq, 0);

    // R9 unqualified clear has no effect
    busWrite(5'd0, ctrlWord(1'b0, 1'b1, 2'd3, 1'b1));
    waitIdle(n);
    chk("R7 flag after cycle", irq, 1);
    busWrite(5'd1, 8'h02);
    chk("R9 unqualified clear ignored", irq, 1);
    busRead(5'd1, d); chk("R9 status readback", d, 8'h01);
    busWrite(5'd1, 8'h02);
    chk("R9 clear after read", irq, 0);

    // R10 set and qualified clear on the same edge
    busWrite(5'd0, ctrlWord(1'b0, 1'b1, 2'd3, 1'b1));
    waitIdle(n);
    busRead(5'd1, d);
    busWrite(5'd0, ctrlWord(1'b0, 1'b1, 2'd3, 1'b1));
    repeat (cycleLen(3) - 1) @(negedge clk);
    busAddr = 5'd1; busWdata = 8'h02; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    chk("R10 cycle ended on collision edge", scanBusy, 0);
    chk("R10 set wins", irq, 1);
    busWrite(5'd1, 8'h02);
    chk("R10 qualification consumed", irq, 1);
    clearFlag();
    chk("R10 fresh handshake clears", irq, 0);

    // R6 slave copy only at cycle start
    for (int g = 0; g < NG; g++) begin
      busWrite(5'(8 + 2*g), 8'(8'h10 + g));
      busWrite(5'(9 + 2*g), 8'(g + 1));
    end
    busWrite(5'd0, ctrlWord(1'b0, 1'b1, 2'd3, 1'b0));
    for (int g = 0; g < NG; g++) begin
      chk($sformatf("R6 slave data g%0d at start", g), slaveData[g*DW +: DW], 8'h10 + g);
      chk($sformatf("R6 slave mode g%0d at start", g), slaveMode[g*MW +: MW], g + 1);
      busWrite(5'(8 + 2*g), 8'(8'hA0 + g));
    end
    busRead(5'd8, d); chk("R6 master readback", d, 8'hA0);
    chk("R6 slave held mid-cycle", slaveData[DW-1:0], 8'h10);
    waitIdle(n);
    chk("R6 slave held after end", slaveData[NG*DW-1 -: DW], 8'h10 + NG - 1);
    clearFlag();
    busWrite(5'd0, ctrlWord(1'b0, 1'b1, 2'd3, 1'b0));
    for (int g = 0; g < NG; g++)
      chk($sformatf("R6 slave data g%0d next start", g), slaveData[g*DW +: DW], 8'hA0 + g);
    waitIdle(n);
    clearFlag();

    // R5 auto mode: continuous, then stop after turning it off
    busWrite(5'd0, ctrlWord(1'b1, 1'b0, 2'd3, 1'b0));
    badBusy = 0;
    for (int i = 0; i < 3 * cycleLen(3); i++) begin
      @(negedge clk);
      if (!scanBusy) badBusy++;
    end
    chk("R5 busy held in auto mode", badBusy, 0);
    busWrite(5'd8, 8'h5C);
    repeat (cycleLen(3) + 1) @(negedge clk);
    chk("R6/R5 auto reload at next start", slaveData[DW-1:0], 8'h5C);
    busWrite(5'd0, ctrlWord(1'b0, 1'b0, 2'd3, 1'b0));
    repeat (cycleLen(3) + 2) @(negedge clk);
    chk("R5 idle after auto off", scanBusy, 0);
    repeat (cycleLen(3)) @(negedge clk);
    chk("R5 stays idle", scanBusy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule